// File: doc/BRIEF.md
# Shadow Region Cache Policy Controller

This block sits beside the bus controller of a 486-class processor system and decides, for every bus cycle, how the caches treat that cycle. It receives the cycle address, the read/write and code/data status, a cacheable flag and an indication of which bus master owns the cycle. From these inputs and a small set of configuration registers it produces four results:

- a secondary-cache line-fill enable;
- a write-back/write-through hint for the processor's internal cache;
- an active-low external snoop strobe with its address;
- a DRAM write inhibit.

Shadow regions in the upper part of the first megabyte can be marked write-protected. The block then makes them behave like ROM. Writes to such a region never reach DRAM. A processor write to one also produces a snoop strobe, so that the processor drops its internal copy of the line. Every cycle to such a region is marked write-through, so that a write-back internal cache cannot hold writes that never appear on the bus. A separate force bit marks every cycle to the shadow area as write-through, whether the region is protected or not. A fill-mode register limits secondary-cache fills to code, to data, or to both.

Top module: `shadow_cache_policy`

## Requirements
- R1: `fill_en` is high for exactly the one clock after a sampled bus cycle (`cyc_valid` high) that is a read (`cyc_write`=0) with `cyc_cacheable`=1 and that the fill mode allows. Write cycles and non-cacheable reads never raise it.
- R2: Fill mode codes:
  - 2'b00 (unified) fills on every qualifying read.
  - 2'b01 (code only) fills only when `cyc_is_data`=0.
  - 2'b10 (data only) fills only when `cyc_is_data`=1.
  - 2'b11 behaves exactly like 2'b00.
- R3: A configuration write takes effect from the next bus cycle. A bus cycle sampled on the same clock edge as the configuration write is still decoded with the old settings.
- R4: Configuration is written when `cfg_we` is high, with `cfg_sel` choosing the register:
  - 0 selects the fill mode, taken from `cfg_wdata[1:0]`.
  - 1 selects the protect mask, taken from `cfg_wdata[8:0]`.
  - 2 selects the force bit, taken from `cfg_wdata[0]`.
  - 3 writes nothing.

  All three registers reset to 0.
- R5: Region map:
  - Regions 0 to 7 are 16 KB each, and region i covers C0000h+i*4000h to C3FFFh+i*4000h.
  - Region 8 covers F0000h to FFFFFh.
  - Mask bit i protects region i.
  - No address at or above 100000h, and none from E0000h to EFFFFh, is in any region.
- R6: `dram_wr_block` is high for the one clock after a sampled write cycle to a protected region, whoever the bus master is. It is low for every other cycle.
- R7: After a sampled write to a protected region with `cyc_cpu`=1, `snoop_n` goes low for exactly one clock. That clock is the second after the sampling edge, and `snoop_addr` equals the write address during it. A write with `cyc_cpu`=0 produces no strobe.
- R8: `wb_hint` (1 = write-back, 0 = write-through) is valid for the one clock after a sampled cycle. It is 1 only for a cacheable cycle that is outside every protected region and that is not a shadow-region cycle while the force bit is set. A protected region therefore fills write-through.
- R9: After reset, and in any clock not preceded by a sampled cycle, `fill_en`, `wb_hint` and `dram_wr_block` are 0 and `snoop_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 9 | Configuration write data |
| cyc_valid | input | 1 | Bus cycle is presented this clock |
| cyc_addr | input | 32 | Bus cycle byte address |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_is_data | input | 1 | 1 = data cycle, 0 = code fetch |
| cyc_cacheable | input | 1 | Address is cacheable |
| cyc_cpu | input | 1 | 1 = processor is the bus master |
| fill_en | output | 1 | Secondary-cache line fill enable |
| wb_hint | output | 1 | 1 = write-back, 0 = write-through |
| dram_wr_block | output | 1 | Suppress the DRAM write |
| snoop_n | output | 1 | Active-low external snoop strobe |
| snoop_addr | output | 32 | Address accompanying the snoop strobe |

## Verification
The fill, hint and inhibit results are registered once, so they are due one clock after the edge that samples `cyc_valid`. The snoop strobe goes through a second register and is due one clock after that. Each directed scenario drives a cycle on a falling edge and reads the first group at the next falling edge. It then drops `cyc_valid` and reads `snoop_n` and `snoop_addr` one falling edge later. One more falling edge confirms that the strobe has returned high. A configuration write issued together with a bus cycle is checked against the old settings, and the next cycle is checked against the new ones.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int ADDR_W      = 32;
    localparam int N_SMALL     = 8;
    localparam int SMALL_LOG2  = 14;
    localparam int BIG_LOG2    = 16;
    localparam int N_REGION    = N_SMALL + 1;
    localparam int CFG_W       = (N_REGION > 2) ? N_REGION : 2;
    localparam logic [ADDR_W-1:0] SMALL_BASE = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] BIG_BASE   = ADDR_W'(32'h000F_0000);

    typedef enum logic [1:0] {
        FM_UNIFIED = 2'b00,
        FM_CODE    = 2'b01,
        FM_DATA    = 2'b10,
        FM_RSVD    = 2'b11
    } fill_mode_e;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_FORCE = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              is_data;
        logic              cacheable;
        logic              cpu;
    } bus_cyc_t;

    typedef struct packed {
        logic              fill;
        logic              wb;
        logic              block;
        logic              snoop_req;
        logic [ADDR_W-1:0] addr;
    } decision_t;

    function automatic logic mode_allows(fill_mode_e m, logic is_data);
        case (m)
            FM_CODE: return !is_data;
            FM_DATA: return is_data;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/scp_cfg_regs.sv
module scp_cfg_regs
    import scp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [1:0]          sel,
    input  logic [CFG_W-1:0]    wdata,
    output fill_mode_e          mode,
    output logic [N_REGION-1:0] mask,
    output logic                force_wt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= FM_UNIFIED;
            mask     <= '0;
            force_wt <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_MODE:  mode     <= fill_mode_e'(wdata[1:0]);
                SEL_MASK:  mask     <= wdata[N_REGION-1:0];
                SEL_FORCE: force_wt <= wdata[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/scp_region_decode.sv
module scp_region_decode
    import scp_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output logic [N_REGION-1:0] hit
);
    for (genvar i = 0; i < N_SMALL; i++) begin : g_small
        localparam logic [ADDR_W-1:0] BASE =
            SMALL_BASE + ADDR_W'(i) * ADDR_W'(1 << SMALL_LOG2);
        assign hit[i] = ((addr >> SMALL_LOG2) == (BASE >> SMALL_LOG2));
    end

    assign hit[N_SMALL] = ((addr >> BIG_LOG2) == (BIG_BASE >> BIG_LOG2));
endmodule

// File: rtl/scp_snoop_gen.sv
module scp_snoop_gen
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              snoop_n,
    output logic [ADDR_W-1:0] snoop_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snoop_n    <= 1'b1;
            snoop_addr <= '0;
        end else begin
            snoop_n <= !req;
            if (req) snoop_addr <= req_addr;
        end
    end
endmodule

// File: rtl/shadow_cache_policy.sv
module shadow_cache_policy
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic              cyc_is_data,
    input  logic              cyc_cacheable,
    input  logic              cyc_cpu,
    output logic              fill_en,
    output logic              wb_hint,
    output logic              dram_wr_block,
    output logic              snoop_n,
    output logic [ADDR_W-1:0] snoop_addr
);
    fill_mode_e          mode;
    logic [N_REGION-1:0] mask;
    logic                force_wt;
    logic [N_REGION-1:0] region_hit;
    logic                prot_hit;
    logic                shadow_hit;
    bus_cyc_t            cyc;
    decision_t           nxt;
    decision_t           dec_q;

    scp_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .mode     (mode),
        .mask     (mask),
        .force_wt (force_wt)
    );

    assign cyc = '{addr: cyc_addr, write: cyc_write, is_data: cyc_is_data,
                   cacheable: cyc_cacheable, cpu: cyc_cpu};

    scp_region_decode u_dec (
        .addr (cyc.addr),
        .hit  (region_hit)
    );

    assign prot_hit   = |(region_hit & mask);
    assign shadow_hit = |region_hit;

    always_comb begin
        nxt.fill      = cyc_valid && !cyc.write && cyc.cacheable &&
                        mode_allows(mode, cyc.is_data);
        nxt.block     = cyc_valid && cyc.write && prot_hit;
        nxt.wb        = cyc_valid && cyc.cacheable && !prot_hit &&
                        !(force_wt && shadow_hit);
        nxt.snoop_req = cyc_valid && cyc.write && prot_hit && cyc.cpu;
        nxt.addr      = cyc.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= nxt;
    end

    scp_snoop_gen u_snoop (
        .clk        (clk),
        .rst        (rst),
        .req        (dec_q.snoop_req),
        .req_addr   (dec_q.addr),
        .snoop_n    (snoop_n),
        .snoop_addr (snoop_addr)
    );

    assign fill_en       = dec_q.fill;
    assign wb_hint       = dec_q.wb;
    assign dram_wr_block = dec_q.block;
endmodule

// File: rtl/shadow_cache_policy_chk.sv
module shadow_cache_policy_chk
    import scp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cyc_valid,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              cyc_write,
    input logic              cyc_cacheable,
    input logic              fill_en,
    input logic              wb_hint,
    input logic              dram_wr_block,
    input logic              snoop_n,
    input logic [ADDR_W-1:0] snoop_addr
);
    a_r1_fill_needs_read: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> $past(cyc_valid && !cyc_write && cyc_cacheable));

    a_r6_block_needs_write: assert property (@(posedge clk) disable iff (rst)
        dram_wr_block |-> $past(cyc_valid && cyc_write));

    a_r7_snoop_after_block: assert property (@(posedge clk) disable iff (rst)
        !snoop_n |-> $past(dram_wr_block));

    a_r7_snoop_addr: assert property (@(posedge clk) disable iff (rst)
        !snoop_n |-> (snoop_addr == $past(cyc_addr, 2)));

    a_r8_protected_is_wt: assert property (@(posedge clk) disable iff (rst)
        dram_wr_block |-> !wb_hint);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(cyc_valid) |-> (!fill_en && !wb_hint && !dram_wr_block));
endmodule

bind shadow_cache_policy shadow_cache_policy_chk u_chk (.*);

// File: tb/tb_shadow_cache_policy.sv
`timescale 1ns/1ps
module tb_shadow_cache_policy;
    import scp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic              cyc_valid = 1'b0;
    logic [ADDR_W-1:0] cyc_addr = '0;
    logic              cyc_write = 1'b0;
    logic              cyc_is_data = 1'b0;
    logic              cyc_cacheable = 1'b0;
    logic              cyc_cpu = 1'b0;
    logic              fill_en, wb_hint, dram_wr_block, snoop_n;
    logic [ADDR_W-1:0] snoop_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [1:0]          m_mode  = 2'b00;
    logic [N_REGION-1:0] m_mask  = '0;
    logic                m_force = 1'b0;

    always #2 clk = ~clk;

    shadow_cache_policy dut (.*);

    task automatic chk(input logic cond, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int region_of(input logic [ADDR_W-1:0] a);
        if (a >= 32'h000C_0000 && a < 32'h000E_0000) return int'((a - 32'h000C_0000) >> 14);
        if (a >= 32'h000F_0000 && a < 32'h0010_0000) return 8;
        return -1;
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [CFG_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_mode = d[1:0];
        if (sel == 2'd1) m_mask = d[N_REGION-1:0];
        if (sel == 2'd2) m_force = d[0];
    endtask

    // Drives one bus cycle, checks the decisions one clock later and the snoop strobe after that.
    task automatic bus_cycle(input logic [ADDR_W-1:0] a, input logic wr, input logic dat,
                             input logic cch, input logic cpu, input string tag,
                             input bit with_cfg = 0, input logic [1:0] csel = 0,
                             input logic [CFG_W-1:0] cdat = 0);
        int  r;
        bit  prot, shad, e_fill, e_wb, e_blk, e_snp;
        r    = region_of(a);
        shad = (r >= 0);
        prot = shad && m_mask[r];
        e_fill = !wr && cch && ((m_mode == 2'b01) ? !dat : (m_mode == 2'b10) ? dat : 1'b1);
        e_wb   = cch && !prot && !(m_force && shad);
        e_blk  = wr && prot;
        e_snp  = wr && prot && cpu;
        @(negedge clk);
        cyc_valid = 1; cyc_addr = a; cyc_write = wr; cyc_is_data = dat;
        cyc_cacheable = cch; cyc_cpu = cpu;
        if (with_cfg) begin cfg_we = 1; cfg_sel = csel; cfg_wdata = cdat; end
        @(negedge clk);
        cyc_valid = 0; cfg_we = 0;
        if (with_cfg) begin
            if (csel == 2'd0) m_mode = cdat[1:0];
            if (csel == 2'd1) m_mask = cdat[N_REGION-1:0];
            if (csel == 2'd2) m_force = cdat[0];
        end
        chk(fill_en == e_fill, tag, "fill_en", fill_en, e_fill);
        chk(wb_hint == e_wb, tag, "wb_hint", wb_hint, e_wb);
        chk(dram_wr_block == e_blk, tag, "dram_wr_block", dram_wr_block, e_blk);
        @(negedge clk);
        chk(snoop_n == !e_snp, tag, "snoop_n", snoop_n, !e_snp);
        if (e_snp) chk(snoop_addr == a, tag, "snoop_addr", snoop_addr, a);
        chk(!fill_en && !wb_hint && !dram_wr_block, "R9", "idle outputs",
            {fill_en, wb_hint, dram_wr_block}, 0);
        @(negedge clk);
        chk(snoop_n == 1'b1, "R7", "snoop single clock", snoop_n, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!fill_en && !wb_hint && !dram_wr_block, "R9", "reset outputs",
            {fill_en, wb_hint, dram_wr_block}, 0);
        chk(snoop_n == 1'b1, "R9", "reset snoop_n", snoop_n, 1);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_fill_basic;
        bus_cycle(32'h0001_0000, 0, 1, 1, 1, "R1");
        bus_cycle(32'h0001_0000, 1, 1, 1, 1, "R1");
        bus_cycle(32'h0001_0000, 0, 1, 0, 1, "R1");
        bus_cycle(32'h0001_0000, 0, 0, 1, 1, "R1");
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            cfg_write(2'd0, CFG_W'(m));
            bus_cycle(32'h0002_0040, 0, 0, 1, 1, "R2");
            bus_cycle(32'h0002_0040, 0, 1, 1, 1, "R2");
        end
        cfg_write(2'd0, CFG_W'(0));
    endtask

    task automatic t_mode_switch;
        bus_cycle(32'h0003_0000, 0, 1, 1, 1, "R3", 1, 2'd0, CFG_W'(1));
        bus_cycle(32'h0003_0000, 0, 1, 1, 1, "R3");
        bus_cycle(32'h000C_0000, 1, 1, 1, 1, "R3", 1, 2'd1, CFG_W'(1));
        bus_cycle(32'h000C_0000, 1, 1, 1, 1, "R3");
        cfg_write(2'd0, CFG_W'(0));
        cfg_write(2'd1, '0);
    endtask

    task automatic t_regions;
        cfg_write(2'd1, CFG_W'(9'b1_0000_0010));
        bus_cycle(32'h000C_3FFF, 1, 1, 1, 1, "R5");
        bus_cycle(32'h000C_4000, 1, 1, 1, 1, "R5");
        bus_cycle(32'h000C_7FFF, 1, 1, 1, 0, "R5");
        bus_cycle(32'h000F_0000, 1, 1, 1, 1, "R5");
        bus_cycle(32'h000F_FFFC, 0, 0, 1, 1, "R5");
        bus_cycle(32'h001F_0000, 1, 1, 1, 1, "R5");
        cfg_write(2'd1, CFG_W'(9'h0FF));
        bus_cycle(32'h000D_FFFF, 1, 1, 1, 1, "R5");
        bus_cycle(32'h000E_8000, 1, 1, 1, 1, "R5");
        cfg_write(2'd3, '1);
        bus_cycle(32'h000F_8000, 1, 1, 1, 1, "R4");
        bus_cycle(32'h0004_0000, 0, 1, 1, 1, "R4");
    endtask

    task automatic t_protect;
        cfg_write(2'd1, CFG_W'(9'b0_0000_1000));
        bus_cycle(32'h000C_C010, 1, 1, 1, 1, "R7");
        bus_cycle(32'h000C_C020, 1, 1, 1, 0, "R6");
        bus_cycle(32'h000C_C020, 0, 0, 1, 1, "R8");
        bus_cycle(32'h000D_0000, 1, 1, 1, 1, "R6");
        cfg_write(2'd1, '0);
    endtask

    task automatic t_force;
        cfg_write(2'd2, CFG_W'(1));
        bus_cycle(32'h000C_8000, 1, 1, 1, 1, "R8");
        bus_cycle(32'h000F_1000, 0, 1, 1, 1, "R8");
        bus_cycle(32'h0005_0000, 1, 1, 1, 1, "R8");
        cfg_write(2'd2, CFG_W'(0));
        bus_cycle(32'h000C_8000, 1, 1, 1, 1, "R8");
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_fill_basic();
        t_modes();
        t_mode_switch();
        t_regions();
        t_protect();
        t_force();
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule